// File: doc/BRIEF.md
# Dual-Rail Word Conversion and Balanced XOR Unit

This unit runs inside the execute stage of a soft processor as a custom-instruction engine. Software uses it to keep sensitive values in a balanced two-rail encoding. In that encoding every plain bit is stored beside its own inverse, so any value written into such a word has the same number of ones as any other. The unit converts a plain 32-bit word into two such encoded words, one per half. It converts an encoded word back to plain form. It also computes an exclusive-OR directly on encoded operands.

Each command takes two cycles. In the first cycle, called precharge, the result register is cleared to all zeros. In the second cycle the answer is written into that register. Across every bit pair of a valid encoded result, one rail rises from 0 to 1 and the other stays at 0. The processor presents an opcode and two operands with a start strobe. It collects the result when the one-cycle done flag appears.

Top module: `drx_unit`

## Requirements
- R1: While the synchronous active-high reset is asserted, result_o reads zero and done_o is low.
- R2: In an encoded word, plain bit i sits at position 2i and its inverse sits at position 2i+1.
- R3: Opcode 1 (spread low) returns the encoded form of opa_i bits 15..0.
- R4: Opcode 2 (spread high) returns the encoded form of opa_i bits 31..16.
- R5: Opcode 0 (gather) places the even-position bits of opa_i, in order, into result bits 15..0. Result bits 31..16 are zero.
- R6: Opcode 3 (balanced XOR) puts the XOR of the even (true) bits of opa_i and opb_i on each even position, and its inverse on the odd position beside it. The odd bits of both operands have no effect on the result.
- R7: Opcodes 4 to 7 return an all-zero result.
- R8: A start accepted at a clock edge clears result_o to zero at that edge, with done_o low: this is the precharge cycle.
- R9: At the next edge the result is loaded and done_o rises for exactly one cycle. The result then holds until the next accepted start.
- R10: A start seen during the evaluation cycle is ignored.
- R11: Opcode and operands are captured with the accepted start. Later changes to them do not alter the pending result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Command strobe |
| op_i | input | 3 | Operation select |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand (XOR only) |
| result_o | output | 32 | Registered result |
| done_o | output | 1 | One-cycle completion flag |

## Verification
A stuck or wrongly advancing sequencer shows at the ports within two cycles of a start. The symptoms are a missing precharge zero, a missing or doubled done pulse, or a result that changes while no command is pending. A wrong per-bit-pair mapping shows the moment done rises, as a pair that is not one-hot or as a bit in the wrong place. A bad capture register only shows when the operands change while a command is in flight, so the bench changes them on purpose in that window.

// File: rtl/drx_pkg.sv
package drx_pkg;

    localparam int unsigned DRX_PW  = 32;
    localparam int unsigned DRX_OPW = 3;

    typedef enum logic [DRX_OPW-1:0] {
        OP_GATHER    = 3'd0,
        OP_SPREAD_LO = 3'd1,
        OP_SPREAD_HI = 3'd2,
        OP_BAL_XOR   = 3'd3
    } drx_op_e;

    typedef enum logic [0:0] {
        SQ_IDLE = 1'b0,
        SQ_EVAL = 1'b1
    } drx_state_e;

    typedef struct packed {
        logic precharge;
        logic load;
    } drx_ctl_t;

    function automatic logic op_is_encoded(input logic [DRX_OPW-1:0] op);
        return (op == OP_SPREAD_LO) || (op == OP_SPREAD_HI) || (op == OP_BAL_XOR);
    endfunction

endpackage

// File: rtl/drx_seq.sv
module drx_seq
    import drx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start_i,
    output drx_ctl_t ctl_o,
    output logic     done_o
);

    drx_state_e state_q;
    logic       done_q;

    always_comb begin
        ctl_o.precharge = (state_q == SQ_IDLE) && start_i;
        ctl_o.load      = (state_q == SQ_EVAL);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            done_q  <= 1'b0;
        end else begin
            done_q <= ctl_o.load;
            if (ctl_o.precharge)
                state_q <= SQ_EVAL;
            else if (ctl_o.load)
                state_q <= SQ_IDLE;
        end
    end

    assign done_o = done_q;

    p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    p_busy_ignores_start_r10: assert property (@(posedge clk) disable iff (rst)
        ctl_o.load |-> !ctl_o.precharge);

    p_eval_follows_pre_r8: assert property (@(posedge clk) disable iff (rst)
        ctl_o.precharge |=> ctl_o.load);

endmodule

// File: rtl/drx_alu.sv
module drx_alu
    import drx_pkg::*;
#(
    parameter int unsigned PW  = DRX_PW,
    parameter int unsigned OPW = DRX_OPW
) (
    input  logic [OPW-1:0] op_i,
    input  logic [PW-1:0]  a_i,
    input  logic [PW-1:0]  b_i,
    output logic [PW-1:0]  y_o
);

    localparam int unsigned HW = PW / 2;

    logic [PW-1:0] spread_lo;
    logic [PW-1:0] spread_hi;
    logic [PW-1:0] bal_xor;
    logic [HW-1:0] gathered;

    for (genvar i = 0; i < HW; i++) begin : g_pair
        logic x_true;
        assign x_true             = a_i[2*i] ^ b_i[2*i];
        assign spread_lo[2*i]     = a_i[i];
        assign spread_lo[2*i+1]   = ~a_i[i];
        assign spread_hi[2*i]     = a_i[HW+i];
        assign spread_hi[2*i+1]   = ~a_i[HW+i];
        assign bal_xor[2*i]       = x_true;
        assign bal_xor[2*i+1]     = ~x_true;
        assign gathered[i]        = a_i[2*i];
    end

    always_comb begin
        case (op_i)
            OP_GATHER:    y_o = {{(PW-HW){1'b0}}, gathered};
            OP_SPREAD_LO: y_o = spread_lo;
            OP_SPREAD_HI: y_o = spread_hi;
            OP_BAL_XOR:   y_o = bal_xor;
            default:      y_o = '0;
        endcase
    end

endmodule

// File: rtl/drx_unit.sv
module drx_unit
    import drx_pkg::*;
#(
    parameter int unsigned PW  = DRX_PW,
    parameter int unsigned OPW = DRX_OPW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start_i,
    input  logic [OPW-1:0] op_i,
    input  logic [PW-1:0]  opa_i,
    input  logic [PW-1:0]  opb_i,
    output logic [PW-1:0]  result_o,
    output logic           done_o
);

    localparam int unsigned HW = PW / 2;

    drx_ctl_t       ctl;
    logic [OPW-1:0] op_q;
    logic [PW-1:0]  a_q;
    logic [PW-1:0]  b_q;
    logic [PW-1:0]  alu_y;
    logic [PW-1:0]  res_q;

    drx_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .ctl_o   (ctl),
        .done_o  (done_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q <= '0;
            a_q  <= '0;
            b_q  <= '0;
        end else if (ctl.precharge) begin
            op_q <= op_i;
            a_q  <= opa_i;
            b_q  <= opb_i;
        end
    end

    drx_alu #(.PW(PW), .OPW(OPW)) u_alu (
        .op_i (op_q),
        .a_i  (a_q),
        .b_i  (b_q),
        .y_o  (alu_y)
    );

    always_ff @(posedge clk) begin
        if (rst)
            res_q <= '0;
        else if (ctl.precharge)
            res_q <= '0;
        else if (ctl.load)
            res_q <= alu_y;
    end

    assign result_o = res_q;

    logic pairs_onehot;
    always_comb begin
        pairs_onehot = 1'b1;
        for (int i = 0; i < HW; i++)
            if (res_q[2*i] == res_q[2*i+1]) pairs_onehot = 1'b0;
    end

    p_precharge_zero_r8: assert property (@(posedge clk) disable iff (rst)
        ctl.precharge |=> (result_o == '0) && !done_o);

    p_eval_from_zero_r8: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $past(result_o) == '0);

    p_pairs_balanced_r2: assert property (@(posedge clk) disable iff (rst)
        (done_o && op_is_encoded(op_q)) |-> pairs_onehot);

    p_gather_upper_r5: assert property (@(posedge clk) disable iff (rst)
        (done_o && op_q == OP_GATHER) |-> result_o[PW-1:HW] == '0);

    p_unknown_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (done_o && op_q > OP_BAL_XOR) |-> result_o == '0);

    p_result_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!ctl.precharge && !ctl.load) |=> $stable(result_o));

endmodule

// File: tb/drx_unit_tb.sv
module drx_unit_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        start_i;
    logic [2:0]  op_i;
    logic [31:0] opa_i;
    logic [31:0] opb_i;
    logic [31:0] result_o;
    logic        done_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    drx_unit u_dut (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .op_i     (op_i),
        .opa_i    (opa_i),
        .opb_i    (opb_i),
        .result_o (result_o),
        .done_o   (done_o)
    );

    function automatic logic [31:0] enc16(input logic [15:0] h);
        logic [31:0] w = '0;
        for (int i = 0; i < 16; i++) begin
            w[2*i]   = h[i];
            w[2*i+1] = !h[i];
        end
        return w;
    endfunction

    function automatic logic [31:0] expect_val(input logic [2:0] op,
                                               input logic [31:0] a,
                                               input logic [31:0] b);
        logic [15:0] t = '0;
        case (op)
            3'd0: begin
                for (int i = 0; i < 16; i++) t[i] = a[2*i];
                return {16'h0, t};
            end
            3'd1: return enc16(a[15:0]);
            3'd2: return enc16(a[31:16]);
            3'd3: begin
                for (int i = 0; i < 16; i++) t[i] = a[2*i] ^ b[2*i];
                return enc16(t);
            end
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string tag_for(input logic [2:0] op);
        case (op)
            3'd0: return "R5 gather";
            3'd1: return "R3 spread-low";
            3'd2: return "R4 spread-high";
            3'd3: return "R6 balanced-xor";
            default: return "R7 unknown-op";
        endcase
    endfunction

    // one command; inputs driven at negedge, outputs sampled at negedge
    task automatic run_op(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
        logic [31:0] e;
        e = expect_val(op, a, b);
        start_i = 1'b1; op_i = op; opa_i = a; opb_i = b;
        @(negedge clk);
        check(result_o == 32'h0 && !done_o, "R8 precharge", result_o, 32'h0);
        start_i = 1'b0; opa_i = ~a; opb_i = ~b; op_i = ~op;   // R11
        @(negedge clk);
        check(done_o == 1'b1, "R9 done rise", {31'h0, done_o}, 32'h1);
        check(result_o == e, tag_for(op), result_o, e);
        @(negedge clk);
        check(done_o == 1'b0 && result_o == e, "R9 pulse/hold", result_o, e);
    endtask

    initial begin
        #(4 * 20000);
        if (!finished) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] held;
        void'($urandom(32'd20240611));
        rst = 1'b1; start_i = 1'b0; op_i = '0; opa_i = '0; opb_i = '0;
        repeat (3) @(negedge clk);
        check(result_o == 32'h0 && !done_o, "R1 reset state", result_o, 32'h0);
        rst = 1'b0;
        @(negedge clk);

        // directed corners
        run_op(3'd1, 32'h0000_0000, 32'h0);      // R2 all-zero -> inverse rails set
        run_op(3'd1, 32'h1234_FFFF, 32'h0);      // R3
        run_op(3'd2, 32'hA5C3_0000, 32'h0);      // R4
        run_op(3'd0, 32'h5555_5555, 32'h0);      // R5 all evens set
        run_op(3'd0, 32'hAAAA_AAAA, 32'h0);      // R5 odd bits only -> zero
        run_op(3'd3, enc16(16'hF0F0), enc16(16'h0FF0)); // R6
        run_op(3'd3, 32'hFFFF_FFFF, 32'h0000_0000);     // R6 invalid odd rails ignored
        for (int k = 4; k < 8; k++) run_op(3'(k), 32'hDEAD_BEEF, 32'hCAFE_F00D); // R7

        // R10: start held into evaluation cycle
        start_i = 1'b1; op_i = 3'd1; opa_i = 32'h0000_3C3C; opb_i = '0;
        @(negedge clk);
        op_i = 3'd3; opa_i = 32'hFFFF_FFFF;      // still strobing while busy
        @(negedge clk);
        held = enc16(16'h3C3C);
        check(done_o && result_o == held, "R10 busy start", result_o, held);
        start_i = 1'b0;
        @(negedge clk);
        check(!done_o && result_o == held, "R10 no restart", result_o, held);
        repeat (2) @(negedge clk);
        check(result_o == held, "R9 idle hold", result_o, held);

        // random mix
        for (int k = 0; k < 60; k++) begin
            logic [2:0]  op = 3'($urandom_range(0, 7));
            logic [31:0] a  = $urandom;
            logic [31:0] b  = $urandom;
            if (op == 3'd3 && k[0]) begin
                a = enc16(a[15:0]);
                b = enc16(b[15:0]);
            end
            run_op(op, a, b);
        end

        // R1 mid-run reset
        rst = 1'b1;
        @(negedge clk);
        check(result_o == 32'h0 && !done_o, "R1 reset clears", result_o, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        run_op(3'd2, 32'h8001_0000, 32'h0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule